// File: doc/BRIEF.md
# Interrupted Instruction Recovery Unit

This block rebuilds the instruction that an interrupt cut off. It is handed the saved interrupt return word, whose bit 0 records whether the interrupted instruction was a 16-bit compressed one. From that word it derives the instruction's start address. It then fetches the first halfword over a simple read port and decodes the instruction length from the opcode's two low bits. A 32-bit instruction needs a second halfword, which the block also fetches. The result is the full instruction word together with a length indicator.

As a sanity check, the block compares the length it decoded against the flag carried in the return word. When the two disagree it raises an error flag. A handler or debug agent uses the outputs to print the instruction as either 4 or 8 hex digits, and to detect a corrupted return word. The handshake is a one-cycle `start_i`, a `busy_o` level and a one-cycle `done_o`.

Top module: `irr_top`

## Requirements
- R1: The instruction address is the return word minus 3 when return bit 0 is 1, and minus 4 when it is 0, taken modulo 2^ADDR_W. It appears on `insn_addr_o` from the cycle after start until the next accepted start, and every read address is even.
- R2: The first read requests the halfword at the instruction address. `rd_req_valid_o` and `rd_addr_o` hold steady until a cycle in which `rd_req_ready_i` is 1.
- R3: If bits [1:0] of the first halfword are both 1, the block issues a second read at the instruction address plus 2. That halfword goes to `insn_word_o[31:16]`, and `insn_wide_o` is 1.
- R4: Otherwise the instruction is 16-bit. Exactly one read is issued, `insn_word_o[31:16]` is zero and `insn_wide_o` is 0.
- R5: At done, `err_o` is 1 exactly when the decoded "is 16-bit" result (`!insn_wide_o`) differs from bit 0 of the return word.
- R6: Read data is taken only on a cycle with `rd_data_valid_i` high that comes after the request's acceptance. Any number of wait cycles on request acceptance and on data return is tolerated.
- R7: `done_o` is high for exactly one cycle per operation. `insn_addr_o`, `insn_word_o`, `insn_wide_o` and `err_o` then stay stable until the next accepted start.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The running operation's results and read count are unaffected.
- R9: Synchronous active-high reset leaves the block idle, with `busy_o`, `done_o`, `err_o` and `rd_req_valid_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| ret_word_i | input | ADDR_W | Saved interrupt return word; bit 0 = compressed flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Halfword-aligned byte address of the read |
| rd_data_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Read halfword |
| insn_addr_o | output | ADDR_W | Address of the recovered instruction |
| insn_word_o | output | 32 | Recovered instruction word |
| insn_wide_o | output | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| err_o | output | 1 | Compressed flag disagrees with the decoded length |

## Verification
The bench builds the block with ADDR_W = 16. At that width the address arithmetic wraps within reach. A return word of 1 or 2 yields an instruction address of 0xFFFE, and the second read of a 32-bit instruction there wraps to address 0. Random return words, opcodes and read-port stalls cover both lengths in matched and mismatched flag combinations.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ_LO,
    S_WAIT_LO,
    S_REQ_HI,
    S_WAIT_HI
  } irr_state_e;

  // A halfword whose two low bits are both set opens a 32-bit instruction.
  function automatic logic opens_wide(input logic [HALF_W-1:0] h);
    return h[0] & h[1];
  endfunction
endpackage

// File: rtl/irr_addr_calc.sv
module irr_addr_calc #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ret_word_i,
  output logic              short_flag_o,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [ADDR_W-1:0] hi_addr_o
);
  localparam logic [ADDR_W-1:0] OFS_SHORT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_LONG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  function automatic logic [ADDR_W-1:0] insn_start(input logic [ADDR_W-1:0] rw);
    return rw - (rw[0] ? OFS_SHORT : OFS_LONG);
  endfunction

  assign short_flag_o = ret_word_i[0];
  assign lo_addr_o    = insn_start(ret_word_i);
  assign hi_addr_o    = lo_addr_o + HALF_STEP;
endmodule

// File: rtl/irr_word_asm.sv
module irr_word_asm
  import irr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wide_o
);
  logic [HALF_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we_i) lo_q <= data_i;
      if (hi_we_i) hi_q <= data_i;
    end
  end

  assign word_o = {hi_q, lo_q};
  assign wide_o = opens_wide(lo_q);

  // R4: the upper half is written only when the low half opened a wide instruction.
  assert_hi_only_wide_R4: assert property (@(posedge clk) disable iff (rst)
    hi_we_i |-> wide_o);
endmodule

// File: rtl/irr_top.sv
module irr_top
  import irr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      ret_word_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   rd_req_valid_o,
  input  logic                   rd_req_ready_i,
  output logic [ADDR_W-1:0]      rd_addr_o,
  input  logic                   rd_data_valid_i,
  input  logic [HALF_W-1:0]      rd_data_i,
  output logic [ADDR_W-1:0]      insn_addr_o,
  output logic [WORD_W-1:0]      insn_word_o,
  output logic                   insn_wide_o,
  output logic                   err_o
);
  irr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ret_q;
  logic              short_flag;
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic              done_q, err_q;

  // Named internal events
  logic start_acc, req_fire, lo_take, hi_take, lo_is_wide, finish, finish_err;

  assign start_acc  = start_i && (state_q == S_IDLE);
  assign req_fire   = rd_req_valid_o && rd_req_ready_i;
  assign lo_take    = (state_q == S_WAIT_LO) && rd_data_valid_i;
  assign hi_take    = (state_q == S_WAIT_HI) && rd_data_valid_i;
  assign lo_is_wide = opens_wide(rd_data_i);
  assign finish     = (lo_take && !lo_is_wide) || hi_take;
  // mismatch: decoded "is 16-bit" differs from saved flag
  assign finish_err = hi_take ? short_flag : !short_flag;

  irr_addr_calc #(.ADDR_W(ADDR_W)) u_addr (
    .ret_word_i   (ret_q),
    .short_flag_o (short_flag),
    .lo_addr_o    (lo_addr),
    .hi_addr_o    (hi_addr)
  );

  irr_word_asm u_asm (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_acc),
    .lo_we_i (lo_take),
    .hi_we_i (hi_take),
    .data_i  (rd_data_i),
    .word_o  (insn_word_o),
    .wide_o  (insn_wide_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_acc) state_d = S_REQ_LO;
      S_REQ_LO:  if (req_fire) state_d = S_WAIT_LO;
      S_WAIT_LO: if (lo_take) state_d = lo_is_wide ? S_REQ_HI : S_IDLE;
      S_REQ_HI:  if (req_fire) state_d = S_WAIT_HI;
      S_WAIT_HI: if (hi_take) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ret_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (start_acc) begin
        ret_q <= ret_word_i;
        err_q <= 1'b0;
      end else if (finish) begin
        err_q <= finish_err;
      end
    end
  end

  assign busy_o         = (state_q != S_IDLE);
  assign done_o         = done_q;
  assign err_o          = err_q;
  assign insn_addr_o    = lo_addr;
  assign rd_req_valid_o = (state_q == S_REQ_LO) || (state_q == S_REQ_HI);
  assign rd_addr_o      = (state_q == S_REQ_HI) ? hi_addr : lo_addr;

  // ---------------- assertions ----------------
  assert_addr_even_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid_o |-> !rd_addr_o[0]);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_addr_o));

  assert_hi_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_REQ_HI) |-> rd_addr_o == ADDR_W'(insn_addr_o + ADDR_W'(2)));

  assert_short_upper_R4: assert property (@(posedge clk) disable iff (rst)
    done_o && !insn_wide_o |-> insn_word_o[WORD_W-1:HALF_W] == '0);

  assert_err_match_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> err_o == (insn_wide_o == short_flag));

  assert_no_req_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rd_req_valid_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !start_i |=> $stable(insn_word_o) && $stable(err_o) && $stable(insn_addr_o));

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(insn_addr_o));
endmodule

// File: tb/irr_top_tb.sv
module irr_top_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic [AW-1:0] ret_word_i;
  logic          busy_o, done_o, rd_req_valid_o;
  logic          rd_req_ready_i;
  logic [AW-1:0] rd_addr_o;
  logic          rd_data_valid_i;
  logic [15:0]   rd_data_i;
  logic [AW-1:0] insn_addr_o;
  logic [31:0]   insn_word_o;
  logic          insn_wide_o, err_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  irr_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .ret_word_i(ret_word_i),
    .busy_o(busy_o), .done_o(done_o), .rd_req_valid_o(rd_req_valid_o),
    .rd_req_ready_i(rd_req_ready_i), .rd_addr_o(rd_addr_o),
    .rd_data_valid_i(rd_data_valid_i), .rd_data_i(rd_data_i),
    .insn_addr_o(insn_addr_o), .insn_word_o(insn_word_o),
    .insn_wide_o(insn_wide_o), .err_o(err_o)
  );

  // ---------------- memory model ----------------
  logic [15:0]   mem [256];
  logic          pend;
  logic [AW-1:0] paddr;
  int            lat;
  int            req_cnt;
  logic [AW-1:0] req_log [4];

  always @(posedge clk) begin
    rd_data_valid_i <= 1'b0;
    if (rst) begin
      pend           <= 1'b0;
      rd_req_ready_i <= 1'b0;
      lat            <= 0;
    end else begin
      rd_req_ready_i <= ($urandom % 4) != 0;
      if (rd_req_valid_o && rd_req_ready_i) begin
        pend  <= 1'b1;
        paddr <= rd_addr_o;
        lat   <= $urandom % 3;
        if (req_cnt < 4) req_log[req_cnt] <= rd_addr_o;
        req_cnt <= req_cnt + 1;
      end else if (pend) begin
        if (lat == 0) begin
          rd_data_valid_i <= 1'b1;
          rd_data_i       <= mem[paddr[8:1]];
          pend            <= 1'b0;
        end else begin
          lat <= lat - 1;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] rw);
    logic [AW-1:0] even = {rw[AW-1:1], 1'b0};
    return rw[0] ? even - AW'(2) : even - AW'(4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o) begin got = 1'b1; break; end
    end
  endtask

  // one operation: lo halfword given, hi halfword given, return word given
  task automatic run_op(input logic [AW-1:0] rw, input logic [15:0] lo,
                        input logic [15:0] hi, input bit extra_start);
    logic [AW-1:0] a    = exp_addr(rw);
    logic [AW-1:0] a2   = a + AW'(2);
    bit            wide = (lo[1:0] == 2'b11);
    logic [31:0]   expw = wide ? {hi, lo} : {16'h0, lo};
    bit            experr = (!wide) != rw[0];
    bit            got;
    logic [31:0]   w_hold;
    mem[a[8:1]]  = lo;
    mem[a2[8:1]] = hi;
    @(negedge clk);
    req_cnt    = 0;
    start_i    = 1'b1;
    ret_word_i = rw;
    @(negedge clk);
    start_i    = 1'b0;
    if (extra_start) begin
      // R8: a start while busy must be ignored
      chk(busy_o, "R8", "busy after start", busy_o, 1);
      start_i    = 1'b1;
      ret_word_i = rw ^ AW'(16'h0100);
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done(got);
    chk(got, "R7", "done seen", got, 1);
    chk(insn_addr_o == a, "R1", "insn addr", insn_addr_o, a);
    chk(insn_word_o == expw, wide ? "R3" : "R4", "insn word", insn_word_o, expw);
    chk(insn_wide_o == wide, wide ? "R3" : "R4", "wide flag", insn_wide_o, wide);
    chk(err_o == experr, "R5", "err", err_o, experr);
    chk(req_cnt == (wide ? 2 : 1), "R6", "read count", req_cnt, wide ? 2 : 1);
    chk(req_log[0] == a, "R2", "first read addr", req_log[0], a);
    if (wide) chk(req_log[1] == a2, "R3", "second read addr", req_log[1], a2);
    w_hold = insn_word_o;
    @(negedge clk);
    chk(!done_o, "R7", "done one cycle", done_o, 0);
    @(negedge clk);
    @(negedge clk);
    chk(insn_word_o == w_hold && err_o == experr, "R7", "outputs held",
        insn_word_o, w_hold);
    if (extra_start) chk(req_cnt == (wide ? 2 : 1), "R8", "no extra reads", req_cnt, wide ? 2 : 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    req_cnt    = 0;
    rst        = 1'b1;
    start_i    = 1'b0;
    ret_word_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(!busy_o && !done_o && !err_o && !rd_req_valid_o, "R9", "reset state",
        {busy_o, done_o, err_o, rd_req_valid_o}, 0);

    // directed corners
    run_op(16'h0105, 16'h0001, 16'hAAAA, 0);  // compressed, 16-bit, match
    run_op(16'h0204, 16'h1233, 16'h5678, 0);  // 32-bit, match
    run_op(16'h0305, 16'h00F3, 16'hBEEF, 0);  // flag set but 32-bit: mismatch
    run_op(16'h0404, 16'h0002, 16'hCAFE, 0);  // flag clear but 16-bit: mismatch
    run_op(16'h0001, 16'h4001, 16'h1111, 0);  // wraps to 0xFFFE, 16-bit
    run_op(16'h0002, 16'hFFFF, 16'h2222, 0);  // 0xFFFE, 32-bit, hi wraps to 0
    run_op(16'h0206, 16'h0013, 16'h0077, 1);  // start while busy ignored (R8)

    // random
    for (int t = 0; t < 40; t++) begin
      logic [AW-1:0] base = AW'(($urandom % 250) * 2 + 4);
      bit            fl   = $urandom % 2;
      logic [15:0]   lo   = 16'($urandom);
      logic [15:0]   hi   = 16'($urandom);
      logic [AW-1:0] rw   = fl ? base + AW'(3) : base + AW'(4);
      run_op(rw, lo, hi, ($urandom % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule